// File: doc/BRIEF.md
# Interrupt Priority and Dispatch Controller

This block decides which pending interruption class a processor core services next and runs the status-word exchange for it. Every cycle while idle it looks at four things: any synchronous exception the core has already raised, the five-bit pending vector, the enable bits in the current status word, and the per-subclass I/O occupancy flags. When a class wins, the block registers a one-cycle `take` strobe. With that strobe it gives the class, any injected external code, one-cycle queue-pop strobes and one-cycle pending-clear strobes.

The block then enters a swap phase. It holds `swap_req` high and presents the old status word, which carries the current condition code, together with the old instruction address. It waits until the memory side returns the new status word on `swap_ack`. On that acknowledge it loads the new word, takes the condition code out of it, and reports a halt or stop request taken from the new word's wait and enable bits. It also updates `irq_req`, which tells the core whether any interruption is still pending.

Top module: `irq_dispatch_ctrl`

## Requirements
- R1: A raised synchronous exception (`sync_kind` 1 = program, 2 = supervisor call) is taken at once as class 1 or class 2. Pending asynchronous sources and their enable bits do not affect this.
- R2: The asynchronous classes are checked in fixed order: machine check (class 5, status bit 50, pending bit 0), then external (class 3, status bit 56, pending bits 1 to 3), then I/O (class 4, status bit 57, pending bit 4). A class is considered only when its status bit is set and no class above it has been chosen. With no class eligible there is no take.
- R3: Within the external class the sources are checked in this order. First the queued request (pending bit 1): it pulses `ext_pop`, uses code 0, and clears pending bit 1 only when `ext_last` is set. Next the clock comparator (pending bit 2), which gives code 0x1004. Last the CPU timer (pending bit 3), which gives code 0x1005.
- R4: When a timer source (code 0x1004 or 0x1005) is turned into an external interruption, pending bits 1 and 2 are cleared and pending bit 3 is not.
- R5: I/O is delivered from the lowest-numbered subclass that is both enabled and occupied. `io_pop` is one-hot on that subclass, and subclasses whose enable bit is clear are skipped.
- R6: The I/O pending bit (clear bit 4) is cleared only when no subclass, enabled or not, still holds entries after the pop. A popped subclass counts as empty afterwards only when its `sub_multi` flag is clear.
- R7: A machine check is taken only when `mck_crw_en` is set and `mck_type` equals 1. It pulses `mck_pop` and clears pending bit 0 when `mck_last` is set. A machine check that is selected but not deliverable gives no take, and it blocks the external and I/O classes.
- R8: The old status word is the current one with bits 45:44 replaced by `cur_cc`. On load, `cc_out` is bits 45:44 of the new word.
- R9: On load, `halt` copies the new word's wait bit (bit 49). `stop_req` pulses when the wait bit is set and bits 50, 56 and 57 are all clear.
- R10: For a supervisor call, `ilen` is `sync_ilen` and the old address is `cur_addr + ilen`. For a program exception, a `sync_ilen` of 2, 4 or 6 is used as it is. Code 0 resolves the length from `op_hi` (0 gives 2, 1 or 2 gives 4, 3 gives 6) and keeps the address unchanged. Code 1 resolves the length the same way and adds it to the address. Asynchronous classes report `ilen` 0 and the unchanged address.
- R11: `take` lasts exactly one cycle. No further take occurs until `swap_ack` has ended the swap phase, even if the inputs that caused the take are still present.
- R12: While idle, `irq_req` follows the OR of the pending vector. On load it becomes the OR of the pending vector with the dispatched clear bits removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_mask | input | PSW_W | Current status word mask |
| cur_cc | input | 2 | Current condition code |
| cur_addr | input | ADDR_W | Current instruction address |
| sync_kind | input | 2 | Raised synchronous exception: 0 none, 1 program, 2 supervisor call |
| sync_ilen | input | 3 | Instruction length, or resolve code 0 or 1 |
| op_hi | input | 2 | Top two bits of the current opcode |
| pend | input | 5 | Pending vector: machine check, external, clock comparator, CPU timer, I/O |
| ext_last | input | 1 | External queue holds exactly one entry |
| mck_last | input | 1 | Machine-check queue holds exactly one entry |
| mck_crw_en | input | 1 | Machine-check report enable from control state |
| mck_type | input | 4 | Type of the head machine-check entry |
| sub_en | input | NSUB | Per-subclass I/O enable |
| sub_occ | input | NSUB | Per-subclass queue non-empty |
| sub_multi | input | NSUB | Per-subclass queue holds more than one entry |
| swap_ack | input | 1 | Memory side finished the status-word exchange |
| new_mask | input | PSW_W | New status word mask, valid with swap_ack |
| new_addr | input | ADDR_W | New instruction address, valid with swap_ack |
| take | output | 1 | One-cycle dispatch strobe |
| cls | output | 3 | Dispatched class |
| ext_code | output | 16 | Injected external code |
| ext_pop | output | 1 | Pop external queue |
| mck_pop | output | 1 | Pop machine-check queue |
| io_pop | output | NSUB | Pop the marked I/O subclass queue |
| pend_clr | output | 5 | One-cycle pending-bit clear strobes |
| ilen | output | 3 | Resolved instruction length |
| swap_req | output | 1 | Exchange in progress |
| old_mask | output | PSW_W | Old status word mask to store |
| old_addr | output | ADDR_W | Old instruction address to store |
| psw_load | output | 1 | One-cycle new-word load strobe |
| psw_mask_out | output | PSW_W | Loaded status word mask |
| psw_addr_out | output | ADDR_W | Loaded instruction address |
| cc_out | output | 2 | Condition code from the loaded word |
| halt | output | 1 | Core halted by the loaded wait bit |
| stop_req | output | 1 | One-cycle stop request |
| irq_req | output | 1 | Interruption still pending |

## Verification
The dispatch outputs (`take`, class, code, pops, clears, old word and length) are due on the first rising edge after the deciding inputs are applied. The load outputs (`psw_load`, `cc_out`, `halt`, `stop_req`, `irq_req`) are due on the first rising edge after `swap_ack`. The bench drives inputs on falling edges. The scoreboard monitor compares results on the next falling edge, so each result is read exactly one register stage after its cause. For cases that must not dispatch, the bench watches several falling edges. It also keeps the triggering inputs held during the swap phase to show that no second take occurs.

// File: rtl/irq_disp_pkg.sv
package irq_disp_pkg;
   localparam int PEND_W = 5;
   localparam int CODE_W = 16;
   localparam int PB_MCK = 0;
   localparam int PB_EXT = 1;
   localparam int PB_CKC = 2;
   localparam int PB_CPT = 3;
   localparam int PB_IO  = 4;

   localparam logic [CODE_W-1:0] CODE_CKC = 16'h1004;
   localparam logic [CODE_W-1:0] CODE_CPT = 16'h1005;

   localparam logic [1:0] SYN_NONE = 2'd0;
   localparam logic [1:0] SYN_PGM  = 2'd1;
   localparam logic [1:0] SYN_SVC  = 2'd2;

   localparam logic [2:0] ILC_LATER     = 3'd0;
   localparam logic [2:0] ILC_LATER_ADV = 3'd1;

   typedef enum logic [2:0] {
      CLS_NONE = 3'd0,
      CLS_PGM  = 3'd1,
      CLS_SVC  = 3'd2,
      CLS_EXT  = 3'd3,
      CLS_IO   = 3'd4,
      CLS_MCK  = 3'd5
   } irq_cls_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_SWAP = 1'b1
   } disp_st_e;
endpackage

// File: rtl/irq_io_scan.sv
module irq_io_scan #(
   parameter int NSUB = 8
) (
   input  logic [NSUB-1:0] sub_en,
   input  logic [NSUB-1:0] sub_occ,
   input  logic [NSUB-1:0] sub_multi,
   output logic            hit,
   output logic [NSUB-1:0] pick,
   output logic            drained
);
   logic [NSUB-1:0] elig;
   logic [NSUB:0]   seen;
   logic [NSUB-1:0] left_over;

   assign elig    = sub_en & sub_occ;
   assign seen[0] = 1'b0;

   for (genvar i = 0; i < NSUB; i++) begin : g_scan
      assign pick[i]   = elig[i] & ~seen[i];
      assign seen[i+1] = seen[i] | elig[i];
   end

   assign hit       = seen[NSUB];
   assign left_over = sub_occ & ~(pick & ~sub_multi);
   assign drained   = ~|left_over;
endmodule

// File: rtl/irq_class_arb.sv
module irq_class_arb
   import irq_disp_pkg::*;
#(
   parameter int NSUB = 8
) (
   input  logic              sync_pgm,
   input  logic              sync_svc,
   input  logic              mck_en,
   input  logic              ext_en,
   input  logic              io_en,
   input  logic [PEND_W-1:0] pend,
   input  logic              mck_ok,
   input  logic              ext_last,
   input  logic              mck_last,
   input  logic              io_hit,
   input  logic              io_drained,
   input  logic [NSUB-1:0]   io_pick,
   output logic              go,
   output irq_cls_e          cls,
   output logic [CODE_W-1:0] code,
   output logic              ext_pop,
   output logic              mck_pop,
   output logic [NSUB-1:0]   io_pop,
   output logic [PEND_W-1:0] clr
);
   logic ext_any;
   assign ext_any = pend[PB_EXT] | pend[PB_CKC] | pend[PB_CPT];

   always_comb begin
      go      = 1'b0;
      cls     = CLS_NONE;
      code    = '0;
      ext_pop = 1'b0;
      mck_pop = 1'b0;
      io_pop  = '0;
      clr     = '0;
      if (sync_pgm) begin
         go  = 1'b1;
         cls = CLS_PGM;
      end else if (sync_svc) begin
         go  = 1'b1;
         cls = CLS_SVC;
      end else if (mck_en && pend[PB_MCK]) begin
         // an undeliverable machine check still blocks lower classes
         if (mck_ok) begin
            go          = 1'b1;
            cls         = CLS_MCK;
            mck_pop     = 1'b1;
            clr[PB_MCK] = mck_last;
         end
      end else if (ext_en && ext_any) begin
         go  = 1'b1;
         cls = CLS_EXT;
         if (pend[PB_EXT]) begin
            ext_pop     = 1'b1;
            clr[PB_EXT] = ext_last;
         end else begin
            code        = pend[PB_CKC] ? CODE_CKC : CODE_CPT;
            clr[PB_EXT] = 1'b1;
            clr[PB_CKC] = 1'b1;
         end
      end else if (io_en && pend[PB_IO] && io_hit) begin
         go         = 1'b1;
         cls        = CLS_IO;
         io_pop     = io_pick;
         clr[PB_IO] = io_drained;
      end
   end
endmodule

// File: rtl/irq_psw_swap.sv
module irq_psw_swap
   import irq_disp_pkg::*;
#(
   parameter int PSW_W    = 64,
   parameter int ADDR_W   = 64,
   parameter int CC_LSB   = 44,
   parameter int WAIT_BIT = 49,
   parameter int MCK_BIT  = 50,
   parameter int EXT_BIT  = 56,
   parameter int IO_BIT   = 57
) (
   input  logic [PSW_W-1:0]  cur_mask,
   input  logic [1:0]        cur_cc,
   input  logic [ADDR_W-1:0] cur_addr,
   input  logic [1:0]        sync_kind,
   input  logic [2:0]        sync_ilen,
   input  logic [1:0]        op_hi,
   input  logic [PSW_W-1:0]  new_mask,
   output logic [PSW_W-1:0]  old_mask,
   output logic [ADDR_W-1:0] old_addr,
   output logic [2:0]        ilen,
   output logic              halt,
   output logic              stop,
   output logic [1:0]        new_cc
);
   logic [2:0] ilen_res;
   logic       ilen_fixed;

   always_comb begin
      unique case (op_hi)
         2'd0:    ilen_res = 3'd2;
         2'd3:    ilen_res = 3'd6;
         default: ilen_res = 3'd4;
      endcase
   end

   assign ilen_fixed = (sync_ilen == 3'd2) || (sync_ilen == 3'd4) || (sync_ilen == 3'd6);

   always_comb begin
      old_mask                = cur_mask;
      old_mask[CC_LSB +: 2]   = cur_cc;
      old_addr                = cur_addr;
      ilen                    = 3'd0;
      if (sync_kind == SYN_SVC) begin
         ilen     = sync_ilen;
         old_addr = cur_addr + ADDR_W'(sync_ilen);
      end else if (sync_kind == SYN_PGM) begin
         if (ilen_fixed) begin
            ilen = sync_ilen;
         end else begin
            ilen = ilen_res;
            if (sync_ilen == ILC_LATER_ADV) begin
               old_addr = cur_addr + ADDR_W'(ilen_res);
            end
         end
      end
   end

   assign halt   = new_mask[WAIT_BIT];
   assign stop   = new_mask[WAIT_BIT] & ~new_mask[IO_BIT] & ~new_mask[EXT_BIT] & ~new_mask[MCK_BIT];
   assign new_cc = new_mask[CC_LSB +: 2];
endmodule

// File: rtl/irq_dispatch_ctrl.sv
module irq_dispatch_ctrl
   import irq_disp_pkg::*;
#(
   parameter int PSW_W    = 64,
   parameter int ADDR_W   = 64,
   parameter int NSUB     = 8,
   parameter int CC_LSB   = 44,
   parameter int WAIT_BIT = 49,
   parameter int MCK_BIT  = 50,
   parameter int EXT_BIT  = 56,
   parameter int IO_BIT   = 57
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PSW_W-1:0]  cur_mask,
   input  logic [1:0]        cur_cc,
   input  logic [ADDR_W-1:0] cur_addr,
   input  logic [1:0]        sync_kind,
   input  logic [2:0]        sync_ilen,
   input  logic [1:0]        op_hi,
   input  logic [4:0]        pend,
   input  logic              ext_last,
   input  logic              mck_last,
   input  logic              mck_crw_en,
   input  logic [3:0]        mck_type,
   input  logic [NSUB-1:0]   sub_en,
   input  logic [NSUB-1:0]   sub_occ,
   input  logic [NSUB-1:0]   sub_multi,
   input  logic              swap_ack,
   input  logic [PSW_W-1:0]  new_mask,
   input  logic [ADDR_W-1:0] new_addr,
   output logic              take,
   output logic [2:0]        cls,
   output logic [15:0]       ext_code,
   output logic              ext_pop,
   output logic              mck_pop,
   output logic [NSUB-1:0]   io_pop,
   output logic [4:0]        pend_clr,
   output logic [2:0]        ilen,
   output logic              swap_req,
   output logic [PSW_W-1:0]  old_mask,
   output logic [ADDR_W-1:0] old_addr,
   output logic              psw_load,
   output logic [PSW_W-1:0]  psw_mask_out,
   output logic [ADDR_W-1:0] psw_addr_out,
   output logic [1:0]        cc_out,
   output logic              halt,
   output logic              stop_req,
   output logic              irq_req
);
   localparam int TOP_BIT = PSW_W - 1;

   if (NSUB < 1 || NSUB > 64) begin : g_bad_nsub
      $error("NSUB out of range");
   end
   if (CC_LSB + 1 > TOP_BIT || WAIT_BIT > TOP_BIT || MCK_BIT > TOP_BIT ||
       EXT_BIT > TOP_BIT || IO_BIT > TOP_BIT) begin : g_bad_bits
      $error("status word bit position outside PSW_W");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("ADDR_W too small");
   end

   // ---------------- decision path ----------------
   logic              io_hit, io_drained;
   logic [NSUB-1:0]   io_pick;
   logic              a_go, a_ext_pop, a_mck_pop;
   irq_cls_e          a_cls;
   logic [CODE_W-1:0] a_code;
   logic [NSUB-1:0]   a_io_pop;
   logic [PEND_W-1:0] a_clr;
   logic [PSW_W-1:0]  f_old_mask;
   logic [ADDR_W-1:0] f_old_addr;
   logic [2:0]        f_ilen;
   logic              f_halt, f_stop;
   logic [1:0]        f_cc;

   irq_io_scan #(.NSUB(NSUB)) u_scan (
      .sub_en    (sub_en),
      .sub_occ   (sub_occ),
      .sub_multi (sub_multi),
      .hit       (io_hit),
      .pick      (io_pick),
      .drained   (io_drained)
   );

   irq_class_arb #(.NSUB(NSUB)) u_arb (
      .sync_pgm   (sync_kind == SYN_PGM),
      .sync_svc   (sync_kind == SYN_SVC),
      .mck_en     (cur_mask[MCK_BIT]),
      .ext_en     (cur_mask[EXT_BIT]),
      .io_en      (cur_mask[IO_BIT]),
      .pend       (pend),
      .mck_ok     (mck_crw_en && (mck_type == 4'd1)),
      .ext_last   (ext_last),
      .mck_last   (mck_last),
      .io_hit     (io_hit),
      .io_drained (io_drained),
      .io_pick    (io_pick),
      .go         (a_go),
      .cls        (a_cls),
      .code       (a_code),
      .ext_pop    (a_ext_pop),
      .mck_pop    (a_mck_pop),
      .io_pop     (a_io_pop),
      .clr        (a_clr)
   );

   irq_psw_swap #(
      .PSW_W(PSW_W), .ADDR_W(ADDR_W), .CC_LSB(CC_LSB), .WAIT_BIT(WAIT_BIT),
      .MCK_BIT(MCK_BIT), .EXT_BIT(EXT_BIT), .IO_BIT(IO_BIT)
   ) u_swap (
      .cur_mask  (cur_mask),
      .cur_cc    (cur_cc),
      .cur_addr  (cur_addr),
      .sync_kind (sync_kind),
      .sync_ilen (sync_ilen),
      .op_hi     (op_hi),
      .new_mask  (new_mask),
      .old_mask  (f_old_mask),
      .old_addr  (f_old_addr),
      .ilen      (f_ilen),
      .halt      (f_halt),
      .stop      (f_stop),
      .new_cc    (f_cc)
   );

   // ---------------- sequencing ----------------
   disp_st_e          st_q;
   logic [PEND_W-1:0] clr_hold_q;

   assign swap_req = (st_q == ST_SWAP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q         <= ST_IDLE;
         take         <= 1'b0;
         cls          <= CLS_NONE;
         ext_code     <= '0;
         ext_pop      <= 1'b0;
         mck_pop      <= 1'b0;
         io_pop       <= '0;
         pend_clr     <= '0;
         clr_hold_q   <= '0;
         ilen         <= '0;
         old_mask     <= '0;
         old_addr     <= '0;
         psw_load     <= 1'b0;
         psw_mask_out <= '0;
         psw_addr_out <= '0;
         cc_out       <= '0;
         halt         <= 1'b0;
         stop_req     <= 1'b0;
         irq_req      <= 1'b0;
      end else begin
         take     <= 1'b0;
         ext_pop  <= 1'b0;
         mck_pop  <= 1'b0;
         io_pop   <= '0;
         pend_clr <= '0;
         psw_load <= 1'b0;
         stop_req <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               irq_req <= |pend;
               if (a_go) begin
                  st_q       <= ST_SWAP;
                  take       <= 1'b1;
                  cls        <= a_cls;
                  ext_code   <= a_code;
                  ext_pop    <= a_ext_pop;
                  mck_pop    <= a_mck_pop;
                  io_pop     <= a_io_pop;
                  pend_clr   <= a_clr;
                  clr_hold_q <= a_clr;
                  ilen       <= f_ilen;
                  old_mask   <= f_old_mask;
                  old_addr   <= f_old_addr;
               end
            end
            ST_SWAP: begin
               if (swap_ack) begin
                  st_q         <= ST_IDLE;
                  psw_load     <= 1'b1;
                  psw_mask_out <= new_mask;
                  psw_addr_out <= new_addr;
                  cc_out       <= f_cc;
                  halt         <= f_halt;
                  stop_req     <= f_stop;
                  irq_req      <= |(pend & ~clr_hold_q);
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   // ---------------- properties ----------------
   p_take_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !take);
   p_no_take_in_swap_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (swap_req && !swap_ack) |=> !take);
   p_sync_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (take && $past(sync_kind) == SYN_PGM) |-> cls == CLS_PGM);
   p_ext_needs_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (take && cls == CLS_EXT) |-> $past(cur_mask[EXT_BIT]));
   p_timer_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (take && cls == CLS_EXT && ext_code != '0) |->
         (pend_clr[PB_EXT] && pend_clr[PB_CKC] && !pend_clr[PB_CPT]));
   p_io_pick_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (take && cls == CLS_IO) |->
         ($onehot(io_pop) && ((io_pop & ~$past(sub_en & sub_occ)) == '0)));
   p_mck_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (take && cls == CLS_MCK) |-> ($past(mck_crw_en) && $past(mck_type) == 4'd1));
   p_cc_insert_r8: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> old_mask[CC_LSB +: 2] == $past(cur_cc));
   p_halt_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      psw_load |-> halt == $past(new_mask[WAIT_BIT]));
endmodule

// File: tb/irq_dispatch_ctrl_tb.sv
module irq_dispatch_ctrl_tb_top;
   localparam logic [63:0] M_IO   = 64'h1 << 57;
   localparam logic [63:0] M_EXT  = 64'h1 << 56;
   localparam logic [63:0] M_MCK  = 64'h1 << 50;
   localparam logic [63:0] M_WAIT = 64'h1 << 49;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [63:0] cur_mask, cur_addr, new_mask, new_addr;
   logic [1:0]  cur_cc, sync_kind, op_hi;
   logic [2:0]  sync_ilen;
   logic [4:0]  pend;
   logic        ext_last, mck_last, mck_crw_en, swap_ack;
   logic [3:0]  mck_type;
   logic [7:0]  sub_en, sub_occ, sub_multi;
   logic        take, ext_pop, mck_pop, swap_req, psw_load, halt, stop_req, irq_req;
   logic [2:0]  cls, ilen;
   logic [15:0] ext_code;
   logic [7:0]  io_pop;
   logic [4:0]  pend_clr;
   logic [63:0] old_mask, old_addr, psw_mask_out, psw_addr_out;
   logic [1:0]  cc_out;

   irq_dispatch_ctrl dut_i (.*);

   typedef struct packed {
      logic [63:0] mask; logic [1:0] cc; logic [63:0] addr; logic [1:0] kind;
      logic [2:0] ilc; logic [1:0] op; logic [4:0] pend; logic el; logic ml;
      logic crw; logic [3:0] mt; logic [7:0] en; logic [7:0] occ; logic [7:0] mul;
   } stim_t;
   typedef struct packed {
      logic [2:0] cls; logic [15:0] code; logic ep; logic mp; logic [7:0] iop;
      logic [4:0] clr; logic [2:0] ilen; logic [63:0] oaddr; logic [63:0] omask;
   } exp_take_t;
   typedef struct packed {
      logic halt; logic stop; logic [1:0] cc; logic irq;
   } exp_load_t;

   exp_take_t tq[$];
   exp_load_t lq[$];
   string     ttag[$];
   string     ltag[$];
   int nchk = 0;
   int nerr = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [63:0] ins_cc(input logic [63:0] m, input logic [1:0] c);
      return (m & ~(64'h3 << 44)) | (64'(c) << 44);
   endfunction

   task automatic apply(input stim_t v);
      cur_mask = v.mask; cur_cc = v.cc; cur_addr = v.addr; sync_kind = v.kind;
      sync_ilen = v.ilc; op_hi = v.op; pend = v.pend; ext_last = v.el;
      mck_last = v.ml; mck_crw_en = v.crw; mck_type = v.mt; sub_en = v.en;
      sub_occ = v.occ; sub_multi = v.mul;
   endtask

   // driver: dispatch that is expected to take
   task automatic run_take(input stim_t v, input exp_take_t e, input logic [63:0] nm,
                           input exp_load_t l, input string tag);
      @(negedge clk);
      apply(v);
      tq.push_back(e); ttag.push_back(tag);
      @(negedge clk);
      chk(swap_req === 1'b1, tag, "swap_req after take", 64'(swap_req), 64'd1);
      repeat (2) begin
         @(negedge clk);
         chk(take === 1'b0 && swap_req === 1'b1, "R11", "no second take during swap",
             64'(take), 64'd0);
      end
      new_mask = nm; new_addr = 64'hA000; swap_ack = 1'b1;
      lq.push_back(l); ltag.push_back(tag);
      @(negedge clk);
      swap_ack = 1'b0;
      apply('0);
      @(negedge clk);
   endtask

   // driver: stimulus that must not dispatch
   task automatic run_idle(input stim_t v, input logic exp_irq, input string tag);
      @(negedge clk);
      apply(v);
      repeat (3) begin
         @(negedge clk);
         chk(take === 1'b0 && swap_req === 1'b0, tag, "no take", 64'(take), 64'd0);
      end
      chk(irq_req === exp_irq, "R12", "idle irq_req", 64'(irq_req), 64'(exp_irq));
      apply('0);
      @(negedge clk);
   endtask

   // monitor: pops expectations as results appear
   exp_take_t me;
   exp_load_t ml;
   string     mt;
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (take) begin
            if (tq.size() == 0) begin
               chk(1'b0, "R11", "unexpected take", 64'(cls), 64'd0);
            end else begin
               me = tq.pop_front(); mt = ttag.pop_front();
               chk(cls == me.cls, mt, "class", 64'(cls), 64'(me.cls));
               chk(ext_code == me.code, mt, "ext_code", 64'(ext_code), 64'(me.code));
               chk({ext_pop, mck_pop, io_pop} == {me.ep, me.mp, me.iop}, mt, "pops",
                   64'({ext_pop, mck_pop, io_pop}), 64'({me.ep, me.mp, me.iop}));
               chk(pend_clr == me.clr, mt, "pend_clr", 64'(pend_clr), 64'(me.clr));
               chk(ilen == me.ilen, mt, "ilen", 64'(ilen), 64'(me.ilen));
               chk(old_addr == me.oaddr, mt, "old_addr", old_addr, me.oaddr);
               chk(old_mask == me.omask, "R8", "old_mask", old_mask, me.omask);
            end
         end
         if (psw_load) begin
            if (lq.size() == 0) begin
               chk(1'b0, "R11", "unexpected load", 64'(psw_load), 64'd0);
            end else begin
               ml = lq.pop_front(); mt = ltag.pop_front();
               chk(halt == ml.halt && stop_req == ml.stop, "R9", "halt/stop",
                   64'({halt, stop_req}), 64'({ml.halt, ml.stop}));
               chk(cc_out == ml.cc, "R8", "cc_out", 64'(cc_out), 64'(ml.cc));
               chk(irq_req == ml.irq, "R12", "irq_req after load", 64'(irq_req), 64'(ml.irq));
               chk(psw_addr_out == 64'hA000, mt, "psw_addr_out", psw_addr_out, 64'hA000);
            end
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         nchk++; nerr++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
         $finish;
      end
   end

   initial begin
      stim_t s;
      exp_take_t e;
      swap_ack = 1'b0; new_mask = '0; new_addr = '0;
      apply('0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(take === 1'b0 && swap_req === 1'b0 && irq_req === 1'b0 && halt === 1'b0 &&
          psw_load === 1'b0, "R11", "reset state", 64'({take, swap_req, irq_req, halt}), 64'd0);

      // R2 R12: pending but every class masked
      s = '0; s.pend = 5'b00011;
      run_idle(s, 1'b1, "R2");

      // R1 R8 R10: program exception over enabled external, explicit length
      s = '0; s.mask = M_EXT | (64'h3 << 44) | 64'hFF; s.cc = 2'd2; s.addr = 64'h2000;
      s.kind = 2'd1; s.ilc = 3'd4; s.pend = 5'b00010;
      e = '0; e.cls = 3'd1; e.ilen = 3'd4; e.oaddr = 64'h2000; e.omask = ins_cc(s.mask, 2'd2);
      run_take(s, e, 64'h1 << 44, '{halt:1'b0, stop:1'b0, cc:2'd1, irq:1'b1}, "R1");

      // R10: supervisor call advances address
      s = '0; s.addr = 64'h1000; s.kind = 2'd2; s.ilc = 3'd4;
      e = '0; e.cls = 3'd2; e.ilen = 3'd4; e.oaddr = 64'h1004;
      run_take(s, e, '0, '{halt:1'b0, stop:1'b0, cc:2'd0, irq:1'b0}, "R10");

      // R10: length resolved from opcode, address kept
      s = '0; s.addr = 64'h4000; s.kind = 2'd1; s.ilc = 3'd0; s.op = 2'd3;
      e = '0; e.cls = 3'd1; e.ilen = 3'd6; e.oaddr = 64'h4000;
      run_take(s, e, '0, '{halt:1'b0, stop:1'b0, cc:2'd0, irq:1'b0}, "R10");

      // R10: length resolved and added
      s = '0; s.addr = 64'h4000; s.kind = 2'd1; s.ilc = 3'd1; s.op = 2'd1;
      e = '0; e.cls = 3'd1; e.ilen = 3'd4; e.oaddr = 64'h4004;
      run_take(s, e, '0, '{halt:1'b0, stop:1'b0, cc:2'd0, irq:1'b0}, "R10");

      // R2 R7 R9: machine check beats external and I/O; wait with masks clear stops
      s = '0; s.mask = M_MCK | M_EXT | M_IO; s.addr = 64'h500; s.pend = 5'b10011;
      s.crw = 1'b1; s.mt = 4'd1; s.ml = 1'b1; s.en = 8'hFF; s.occ = 8'h01;
      e = '0; e.cls = 3'd5; e.mp = 1'b1; e.clr = 5'b00001; e.oaddr = 64'h500;
      e.omask = ins_cc(s.mask, 2'd0);
      run_take(s, e, M_WAIT, '{halt:1'b1, stop:1'b1, cc:2'd0, irq:1'b1}, "R7");

      // R7: report enable clear blocks everything below
      s = '0; s.mask = M_MCK | M_EXT; s.pend = 5'b00011; s.crw = 1'b0; s.mt = 4'd1;
      run_idle(s, 1'b1, "R7");
      // R7: unsupported type
      s = '0; s.mask = M_MCK | M_EXT; s.pend = 5'b00011; s.crw = 1'b1; s.mt = 4'd2;
      run_idle(s, 1'b1, "R7");

      // R3 R9: queued external first, not last entry
      s = '0; s.mask = M_EXT | M_IO; s.pend = 5'b10111; s.en = 8'hFF; s.occ = 8'h01;
      e = '0; e.cls = 3'd3; e.ep = 1'b1; e.omask = ins_cc(s.mask, 2'd0);
      run_take(s, e, M_WAIT | M_EXT, '{halt:1'b1, stop:1'b0, cc:2'd0, irq:1'b1}, "R3");

      // R3: queued external, last entry clears bit 1
      s = '0; s.mask = M_EXT; s.pend = 5'b00010; s.el = 1'b1;
      e = '0; e.cls = 3'd3; e.ep = 1'b1; e.clr = 5'b00010; e.omask = ins_cc(s.mask, 2'd0);
      run_take(s, e, '0, '{halt:1'b0, stop:1'b0, cc:2'd0, irq:1'b0}, "R3");

      // R3 R4: clock comparator over CPU timer
      s = '0; s.mask = M_EXT; s.pend = 5'b01100;
      e = '0; e.cls = 3'd3; e.code = 16'h1004; e.clr = 5'b00110; e.omask = ins_cc(s.mask, 2'd0);
      run_take(s, e, '0, '{halt:1'b0, stop:1'b0, cc:2'd0, irq:1'b1}, "R4");

      // R4 R12: CPU timer, its own bit survives
      s = '0; s.mask = M_EXT; s.pend = 5'b01000;
      e = '0; e.cls = 3'd3; e.code = 16'h1005; e.clr = 5'b00110; e.omask = ins_cc(s.mask, 2'd0);
      run_take(s, e, '0, '{halt:1'b0, stop:1'b0, cc:2'd0, irq:1'b1}, "R4");

      // R2: external beats I/O
      s = '0; s.mask = M_EXT | M_IO; s.pend = 5'b10010; s.en = 8'hFF; s.occ = 8'h01;
      e = '0; e.cls = 3'd3; e.ep = 1'b1; e.omask = ins_cc(s.mask, 2'd0);
      run_take(s, e, '0, '{halt:1'b0, stop:1'b0, cc:2'd0, irq:1'b1}, "R2");

      // R5 R6: disabled subclass 2 skipped but keeps I/O pending
      s = '0; s.mask = M_IO; s.pend = 5'b10000; s.en = 8'b0010_0000; s.occ = 8'b0010_0100;
      e = '0; e.cls = 3'd4; e.iop = 8'b0010_0000; e.omask = ins_cc(s.mask, 2'd0);
      run_take(s, e, '0, '{halt:1'b0, stop:1'b0, cc:2'd0, irq:1'b1}, "R5");

      // R6 R12: last entry anywhere clears I/O pending
      s = '0; s.mask = M_IO; s.pend = 5'b10000; s.en = 8'hFF; s.occ = 8'b0000_1000;
      e = '0; e.cls = 3'd4; e.iop = 8'b0000_1000; e.clr = 5'b10000; e.omask = ins_cc(s.mask, 2'd0);
      run_take(s, e, '0, '{halt:1'b0, stop:1'b0, cc:2'd0, irq:1'b0}, "R6");

      // R5 R6: lowest of two, popped one still has more
      s = '0; s.mask = M_IO; s.pend = 5'b10000; s.en = 8'hFF; s.occ = 8'b0000_0100;
      s.mul = 8'b0000_0100;
      e = '0; e.cls = 3'd4; e.iop = 8'b0000_0100; e.omask = ins_cc(s.mask, 2'd0);
      run_take(s, e, '0, '{halt:1'b0, stop:1'b0, cc:2'd0, irq:1'b1}, "R6");
      s = '0; s.mask = M_IO; s.pend = 5'b10000; s.en = 8'hFF; s.occ = 8'b0000_0110;
      e = '0; e.cls = 3'd4; e.iop = 8'b0000_0010; e.omask = ins_cc(s.mask, 2'd0);
      run_take(s, e, '0, '{halt:1'b0, stop:1'b0, cc:2'd0, irq:1'b1}, "R5");

      repeat (3) @(negedge clk);
      chk(tq.size() == 0 && lq.size() == 0, "R11", "all expected results seen",
          64'(tq.size() + lq.size()), 64'd0);
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
         $finish;
      end
   end
endmodule